// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Flag

This block compares two divided-down frequency streams, a reference stream and a feedback stream. Both are sampled on a common system clock. On each rising edge it opens an error window that lasts until the other stream's rising edge arrives. The window drives three outputs. The first is a three-state charge-pump output, modelled as a data bit plus a drive enable. The second is an active-high pump-up pin. The third is an open-drain pin, modelled as a pull-low enable.

A polarity input swaps the meaning of "reference ahead" and "reference behind". This suits loop filters and oscillators whose tuning slope has either sign. A lock flag rises after a run of comparisons whose error stays within a small window.

An activity input turns the block off when low (power save). While it is low, every output shows the locked, idle state. Any half-finished comparison is discarded, so the first comparison after waking starts in phase.

Top module: `pfd_lock_det`

## Requirements
- R1: After reset, cp_oe, cp_val, up_out and dn_pull are 0 and lock is 0.
- R2: With pol_sel = 0, while the reference edge has arrived and the feedback edge has not, the outputs are cp_oe = 1, cp_val = 1, up_out = 0 and dn_pull = 1 (pulling low).
- R3: With pol_sel = 0, while the feedback edge has arrived and the reference edge has not, the outputs are cp_oe = 1, cp_val = 0, up_out = 1 and dn_pull = 0 (released).
- R4: With pol_sel = 1, the two cases above swap output patterns. Reference ahead gives cp_val = 0, up_out = 1, dn_pull = 0. Feedback ahead gives cp_val = 1, up_out = 0, dn_pull = 1. cp_oe = 1 in both.
- R5: With no error pending, including when both edges arrive in the same clock, cp_oe = 0, up_out = 0 and dn_pull = 0 for either pol_sel value.
- R6: Suppose the leading input rises and is first sampled at clock edge k, and the lagging input is first sampled at edge k+d. The active output pattern is then present for exactly d cycles, after edges k to k+d-1. After edge k+d the outputs are idle.
- R7: A comparison counts as good when its error is at most TOL (2) clocks. lock goes high on the clock edge after the NEED-th (4th) consecutive good comparison completes, and it stays high while good comparisons continue.
- R8: A comparison whose error exceeds TOL clears lock and restarts the good-comparison count. The clear takes effect no later than the clock edge after that comparison completes.
- R9: While active = 0, lock = 1 and cp_oe = up_out = dn_pull = 0, without waiting for a clock edge, whatever edges arrive on the inputs.
- R10: Entering power save discards any pending edge. The internal lock state and the good-comparison count are held and resume on wake. An input that rose during power save and is still high at wake starts no comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Divided reference stream, synchronous to clk |
| div_in | input | 1 | Divided feedback stream, synchronous to clk |
| pol_sel | input | 1 | Output polarity select |
| active | input | 1 | 1 = normal operation, 0 = power save |
| cp_val | output | 1 | Charge-pump drive level when enabled |
| cp_oe | output | 1 | Charge-pump drive enable (0 = high impedance) |
| up_out | output | 1 | Active-high pump pin |
| dn_pull | output | 1 | Open-drain pin pull-low enable (0 = released) |
| lock | output | 1 | Lock flag |

## Verification
Two internal faults show up at the ports within one clock: a stuck or mis-set edge flag, and a flag pair that is never cleared. Either one widens or shortens an error pulse, or leaves a drive pattern where the outputs should be idle. A wrong lock counter or tolerance moves the lock transition by a whole comparison period. The bench therefore checks lock on the edge after each comparison completes. Faults in the power-save path show up the moment active changes, or in the first comparison after waking.

// File: rtl/pfd_lock_det.sv
module pfd_lock_det #(
  parameter int TOL  = 2,
  parameter int NEED = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic div_in,
  input  logic pol_sel,
  input  logic active,
  output logic cp_val,
  output logic cp_oe,
  output logic up_out,
  output logic dn_pull,
  output logic lock
);
  localparam int EW = $clog2(TOL + 2);
  localparam int GW = $clog2(NEED + 1);

  logic          ref_q, div_q, ref_f, div_f, lock_q;
  logic [EW-1:0] err;
  logic [GW-1:0] good;

  wire ref_e    = ref_in & ~ref_q;
  wire div_e    = div_in & ~div_q;
  wire done     = ref_f & div_f;
  wire lead     = ref_f & ~div_f;
  wire lag      = div_f & ~ref_f;
  wire pulsing  = lead | lag;
  wire hi_side  = pol_sel ? lag : lead;
  wire lo_side  = pol_sel ? lead : lag;
  wire too_wide = pulsing && (err == EW'(TOL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      div_q  <= 1'b0;
      ref_f  <= 1'b0;
      div_f  <= 1'b0;
      err    <= '0;
      good   <= '0;
      lock_q <= 1'b0;
    end else begin
      ref_q <= ref_in;
      div_q <= div_in;
      if (!active) begin
        ref_f <= 1'b0;
        div_f <= 1'b0;
        err   <= '0;
      end else begin
        if (done) begin
          ref_f <= ref_e;
          div_f <= div_e;
          err   <= '0;
        end else begin
          ref_f <= ref_f | ref_e;
          div_f <= div_f | div_e;
          if (pulsing && err != EW'(TOL + 1)) err <= err + 1'b1;
        end
        if (too_wide) begin
          good   <= '0;
          lock_q <= 1'b0;
        end else if (done && err <= EW'(TOL)) begin
          if (good == GW'(NEED - 1)) lock_q <= 1'b1;
          if (good != GW'(NEED)) good <= good + 1'b1;
        end
      end
    end
  end

  assign cp_oe   = active & pulsing;
  assign cp_val  = active & hi_side;
  assign up_out  = active & lo_side;
  assign dn_pull = active & hi_side;
  assign lock    = ~active | lock_q;
endmodule

// File: rtl/pfd_lock_det_chk.sv
module pfd_lock_det_chk (
  input logic clk,
  input logic rst_n,
  input logic active,
  input logic cp_oe,
  input logic up_out,
  input logic dn_pull,
  input logic lock
);
  AST_PINS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_out && dn_pull)); // R4

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !cp_oe |-> (!up_out && !dn_pull)); // R5

  AST_SAVE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (lock && !cp_oe)); // R9

  AST_LOCK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && $rose(lock)) |-> $past(!cp_oe)); // R7

  AST_LOCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && $fell(lock)) |-> $past(cp_oe)); // R8
endmodule

bind pfd_lock_det pfd_lock_det_chk u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .cp_oe(cp_oe),
  .up_out(up_out), .dn_pull(dn_pull), .lock(lock)
);

// File: tb/pfd_lock_det_test.sv
module pfd_lock_det_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_in = 1'b0, div_in = 1'b0, pol_sel = 1'b0, active = 1'b1;
  logic cp_val, cp_oe, up_out, dn_pull, lock;
  int   n_chk = 0, n_fail = 0, good_m = 0;
  bit   lock_m = 1'b0, finished = 1'b0;

  always #2.5 clk = ~clk;

  pfd_lock_det uut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .div_in(div_in),
    .pol_sel(pol_sel), .active(active), .cp_val(cp_val), .cp_oe(cp_oe),
    .up_out(up_out), .dn_pull(dn_pull), .lock(lock)
  );

  wire [3:0] outs = {cp_oe, cp_val, up_out, dn_pull};

  function automatic logic [3:0] exp_pulse(bit ref_first, bit fc);
    bit hi = fc ? !ref_first : ref_first;
    return {1'b1, hi, !hi, hi};
  endfunction

  task automatic chk4(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s outs act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic chk_lock(string req, bit exp);
    n_chk++;
    if (lock !== exp) begin
      n_fail++;
      $display("FAIL %s lock act=%b exp=%b", req, lock, exp);
    end
  endtask

  task automatic cmp(int d, bit fc);
    bit    rf  = d > 0;
    int    n   = d < 0 ? -d : d;
    string tag = (d == 0) ? "R5" : (fc ? "R4" : (rf ? "R2" : "R3"));
    @(negedge clk);
    pol_sel = fc;
    if (d >= 0) ref_in = 1'b1;
    if (d <= 0) div_in = 1'b1;
    for (int j = 0; j < n; j++) begin
      @(posedge clk); #1;
      chk4({tag, " R6 pulse"}, outs, exp_pulse(rf, fc));
      @(negedge clk);
      if (j == n - 1) begin ref_in = 1'b1; div_in = 1'b1; end
    end
    @(posedge clk); #1;
    chk4("R5 R6 idle after window", outs, 4'b0000);
    @(negedge clk);
    ref_in = 1'b0; div_in = 1'b0;
    @(posedge clk); #1;
    if (n <= 2) begin
      if (good_m < 4) good_m++;
      if (good_m >= 4) lock_m = 1'b1;
    end else begin
      good_m = 0;
      lock_m = 1'b0;
    end
    chk_lock(n <= 2 ? "R7 lock" : "R8 lock", lock_m);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk4("R1 reset outs", outs, 4'b0000);
    chk_lock("R1 reset lock", 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk_lock("R1 lock after release", 1'b0);

    cmp(3, 0); cmp(-3, 0); cmp(2, 1); cmp(-4, 1);
    cmp(0, 0); cmp(0, 1); cmp(1, 0);
    cmp(1, 0); cmp(-2, 1); cmp(0, 0); cmp(2, 0);
    cmp(1, 1); cmp(5, 0); cmp(-3, 1);

    for (int i = 0; i < 80; i++)
      cmp(int'($urandom_range(0, 8)) - 4, 1'($urandom_range(0, 1)));

    for (int i = 0; i < 4; i++) cmp(1, 0);
    @(negedge clk); active = 1'b0; #1;
    chk4("R9 save outs", outs, 4'b0000);
    chk_lock("R9 save lock", 1'b1);
    @(negedge clk); ref_in = 1'b1;
    @(posedge clk); #1;
    chk4("R9 edge ignored in save", outs, 4'b0000);
    @(negedge clk); active = 1'b1;
    @(posedge clk); #1;
    chk4("R10 no stale edge on wake", outs, 4'b0000);
    chk_lock("R10 lock held over save", 1'b1);
    @(negedge clk); ref_in = 1'b0;
    @(posedge clk);
    cmp(2, 1);

    cmp(4, 0);
    cmp(1, 0); cmp(-1, 0); cmp(0, 1);
    @(negedge clk); active = 1'b0; div_in = 1'b1; #1;
    chk_lock("R9 save lock", 1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk); active = 1'b1;
    @(posedge clk); #1;
    chk4("R10 no stale edge on wake", outs, 4'b0000);
    chk_lock("R10 unlocked state held", 1'b0);
    @(negedge clk); div_in = 1'b0;
    @(posedge clk);
    cmp(1, 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule